// File: doc/BRIEF.md
# Byte-Writable Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM whose word is made of several byte lanes. On each rising clock edge it samples an address, three chip enables and the write controls. A selected cycle either writes the word, or some of its byte lanes, or starts a read. Writes land in the array at the sampling edge. Reads return the word at the sampled address.

A static mode input chooses how read data leaves the block. In flow-through mode the array output goes straight to the data port in the cycle after the sampling edge. In pipelined mode it first passes through an output register, which adds one cycle. Deselect takes effect after a single cycle, so a cycle with no read produces no valid data in its own output slot.

Two inputs act without waiting for the clock. The output enable and the sleep input both gate the data port at once. A high-impedance bus is modelled as a zero data word with the valid flag low. While sleep is high, sampled operations are ignored, and the stored contents are kept.

Top module: `sync_byte_sram`

## Requirements
- R1: A cycle is selected only when ce_a_i=1, ce_b_i=1 and ce_n_i=0. On any other combination the cycle neither writes nor produces read data.
- R2: On a selected cycle with gwr_i=1, all lanes of wdata_i are written at addr_i, whatever bwe_i and bsel_i are.
- R3: On a selected cycle with gwr_i=0 and bwe_i=1, only lane j with bsel_i[j]=1 is written. Lane j is wdata_i bits [8j+7:8j]. With bsel_i=0, nothing is written and no read is started.
- R4: A selected cycle with gwr_i=0 and bwe_i=0 is a read of addr_i. bsel_i has no effect on such a cycle.
- R5: With pipe_mode_i=0 (flow-through), the read data and rvalid_o=1 appear in the cycle that follows the sampling edge.
- R6: With pipe_mode_i=1 (pipelined), the read data appears one cycle later than in flow-through mode. Back-to-back reads stream one word per cycle.
- R7: Single-cycle deselect: a sampled cycle that is not a read leaves rvalid_o low in the output slot that belongs to it.
- R8: While oe_i=0, rvalid_o=0 and rdata_o=0 at once, without waiting for a clock edge. Stored data is unaffected.
- R9: While sleep_i=1, rvalid_o=0 at once. Operations sampled while sleep_i=1 are ignored. Stored contents are retained across sleep.
- R10: After reset, rvalid_o=0 and rdata_o=0 until a read completes.
- R11: A word written on one edge is returned by a read sampled on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control and output registers |
| addr_i | input | ADDR_W | Word address |
| ce_a_i | input | 1 | Chip enable, active high |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_n_i | input | 1 | Chip enable, active low |
| gwr_i | input | 1 | Global write: all lanes |
| bwe_i | input | 1 | Byte-write enable |
| bsel_i | input | BYTES | Per-lane write selects |
| wdata_i | input | BYTES*8 | Write data |
| pipe_mode_i | input | 1 | 1 = pipelined read output, 0 = flow-through |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep, high = low-power, data kept |
| rdata_o | output | BYTES*8 | Read data, zero when not driven |
| rvalid_o | output | 1 | Data port driven (models the bus enable) |

## Verification
Every address is first written with a global write while bwe_i=1 and bsel_i=0. This separates the global path from the byte path. Each address is then byte-written with bsel_i equal to its own index, so all sixteen lane masks are tried, and any crossed or dropped lane shows up on read-back. Writes attempted with each chip enable wrong in turn, or under sleep, are followed by reads of the same word to prove nothing changed. A read carrying all byte selects set proves they do not matter on a read. Read-back is done once in flow-through mode with a deselect between reads, and once in pipelined mode as a back-to-back stream. This tells the two latencies apart and checks the single-cycle drop of the valid flag.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [1:0] {
      SBS_IDLE  = 2'd0,
      SBS_READ  = 2'd1,
      SBS_WRITE = 2'd2
   } sbs_op_e;

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
   import sbs_pkg::*;
#(
   parameter int BYTES = 4
) (
   input  logic             ce_a,
   input  logic             ce_b,
   input  logic             ce_n,
   input  logic             sleep,
   input  logic             gwr,
   input  logic             bwe,
   input  logic [BYTES-1:0] bsel,
   output sbs_op_e          op,
   output logic [BYTES-1:0] wmask
);

   logic live;

   always_comb begin
      live  = ce_a & ce_b & ~ce_n & ~sleep;
      op    = SBS_IDLE;
      wmask = '0;
      if (live) begin
         if (gwr) begin
            op    = SBS_WRITE;
            wmask = '1;
         end else if (bwe) begin
            op    = SBS_WRITE;
            wmask = bsel;
         end else begin
            op    = SBS_READ;
         end
      end
   end

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic [BYTES-1:0]  we_mask,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   for (genvar j = 0; j < BYTES; j++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we_mask[j]) cells[waddr] <= wdata[j*BYTE_W +: BYTE_W];
      end

      assign rdata[j*BYTE_W +: BYTE_W] = cells[raddr];
   end

endmodule

// File: rtl/sbs_read_path.sv
module sbs_read_path #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              rd_live,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              oe,
   input  logic              sleep,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [DATA_W-1:0] out_q;
   logic              vld_q;
   logic [DATA_W-1:0] pick_data;
   logic              pick_vld;
   logic              drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         vld_q <= 1'b0;
      end else begin
         out_q <= arr_data;
         vld_q <= rd_live;
      end
   end

   always_comb begin
      pick_data = pipe_mode ? out_q : arr_data;
      pick_vld  = pipe_mode ? vld_q : rd_live;
      drive     = pick_vld & oe & ~sleep;
      rvalid    = drive;
      rdata     = drive ? pick_data : '0;
   end

endmodule

// File: rtl/sync_byte_sram.sv
module sync_byte_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4,
   localparam int BYTE_W = 8,
   localparam int DATA_W = BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_a_i,
   input  logic              ce_b_i,
   input  logic              ce_n_i,
   input  logic              gwr_i,
   input  logic              bwe_i,
   input  logic [BYTES-1:0]  bsel_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              pipe_mode_i,
   input  logic              oe_i,
   input  logic              sleep_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 10)
         else $fatal(1, "sync_byte_sram: ADDR_W out of range");
      assert (BYTES >= 1)
         else $fatal(1, "sync_byte_sram: BYTES must be at least 1");
   end

   sbs_op_e           op;
   logic [BYTES-1:0]  wmask;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic [DATA_W-1:0] arr_q;

   sbs_cmd_decode #(.BYTES(BYTES)) u_dec (
      .ce_a  (ce_a_i),
      .ce_b  (ce_b_i),
      .ce_n  (ce_n_i),
      .sleep (sleep_i),
      .gwr   (gwr_i),
      .bwe   (bwe_i),
      .bsel  (bsel_i),
      .op    (op),
      .wmask (wmask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rd_q   <= 1'b0;
      end else begin
         addr_q <= addr_i;
         rd_q   <= (op == SBS_READ);
      end
   end

   sbs_lane_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
      .clk     (clk),
      .we_mask (wmask),
      .waddr   (addr_i),
      .wdata   (wdata_i),
      .raddr   (addr_q),
      .rdata   (arr_q)
   );

   sbs_read_path #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode_i),
      .rd_live   (rd_q),
      .arr_data  (arr_q),
      .oe        (oe_i),
      .sleep     (sleep_i),
      .rdata     (rdata_o),
      .rvalid    (rvalid_o)
   );

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4,
   localparam int DATA_W = BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              ce_a_i,
   input logic              ce_b_i,
   input logic              ce_n_i,
   input logic              gwr_i,
   input logic              bwe_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              pipe_mode_i,
   input logic              oe_i,
   input logic              sleep_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              rvalid_o
);

   logic sel_now, rd_now, wall_now;
   assign sel_now  = ce_a_i & ce_b_i & ~ce_n_i & ~sleep_i;
   assign rd_now   = sel_now & ~gwr_i & ~bwe_i;
   assign wall_now = sel_now & gwr_i;

   // R1
   flow_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode_i && !(ce_a_i && ce_b_i && !ce_n_i)) |=> (pipe_mode_i || !rvalid_o));

   // R5
   flow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode_i && rd_now) |=> (rvalid_o || pipe_mode_i || !oe_i || sleep_i));

   // R6
   pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode_i && rd_now) ##1 pipe_mode_i |=> (rvalid_o || !pipe_mode_i || !oe_i || sleep_i));

   // R7
   pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode_i && !rd_now) ##1 pipe_mode_i |=> (!pipe_mode_i || !rvalid_o));

   // R8
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |-> (!rvalid_o && rdata_o == '0));

   // R9
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !rvalid_o);

   // R11
   flow_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode_i && wall_now) ##1 (rd_now && addr_i == $past(addr_i)) |=>
         (pipe_mode_i || !oe_i || sleep_i || rdata_o == $past(wdata_i, 2)));

endmodule

bind sync_byte_sram sbs_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_i      (addr_i),
   .ce_a_i      (ce_a_i),
   .ce_b_i      (ce_b_i),
   .ce_n_i      (ce_n_i),
   .gwr_i       (gwr_i),
   .bwe_i       (bwe_i),
   .wdata_i     (wdata_i),
   .pipe_mode_i (pipe_mode_i),
   .oe_i        (oe_i),
   .sleep_i     (sleep_i),
   .rdata_o     (rdata_o),
   .rvalid_o    (rvalid_o)
);

// File: tb/sync_byte_sram_tb_top.sv
`timescale 1ns/1ps
module sync_byte_sram_tb_top;

   localparam int AW = 4;
   localparam int NB = 4;
   localparam int DW = NB * 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          ce_a_i = 1'b0, ce_b_i = 1'b1, ce_n_i = 1'b0;
   logic          gwr_i = 1'b0, bwe_i = 1'b0;
   logic [NB-1:0] bsel_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic          pipe_mode_i = 1'b0;
   logic          oe_i = 1'b1;
   logic          sleep_i = 1'b0;
   logic [DW-1:0] rdata_o;
   logic          rvalid_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] model [DEPTH];

   always #5 clk = ~clk;

   sync_byte_sram #(.ADDR_W(AW), .BYTES(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .ce_a_i(ce_a_i), .ce_b_i(ce_b_i), .ce_n_i(ce_n_i),
      .gwr_i(gwr_i), .bwe_i(bwe_i), .bsel_i(bsel_i), .wdata_i(wdata_i),
      .pipe_mode_i(pipe_mode_i), .oe_i(oe_i), .sleep_i(sleep_i),
      .rdata_o(rdata_o), .rvalid_o(rvalid_o)
   );

   function automatic logic [DW-1:0] fill_val(int a);
      return DW'(a) * 32'h0103_0507 + 32'h8040_2010;
   endfunction

   task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive one sampled cycle from a negedge, return at the following negedge
   task automatic cyc(logic ca, logic cb, logic cn, logic g, logic bw,
                      logic [NB-1:0] bs, int a, logic [DW-1:0] d);
      ce_a_i = ca; ce_b_i = cb; ce_n_i = cn;
      gwr_i = g; bwe_i = bw; bsel_i = bs; addr_i = AW'(a); wdata_i = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 0, '0);
   endtask

   task automatic rd(int a);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, a, '0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R10 reset state
      check("R10 valid", DW'(rvalid_o), '0);
      check("R10 data", rdata_o, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 fill with global write, byte controls set to lane-less byte write
      for (int a = 0; a < DEPTH; a++) begin
         cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0, a, fill_val(a));
         model[a] = fill_val(a);
      end
      // R3 byte writes, select mask = address
      for (int a = 0; a < DEPTH; a++) begin
         logic [DW-1:0] nd;
         nd = ~fill_val(a) ^ 32'h5A5A_5A5A;
         cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, NB'(a), a, nd);
         for (int j = 0; j < NB; j++)
            if (a[j]) model[a][j*8 +: 8] = nd[j*8 +: 8];
      end
      // R1 writes with a wrong enable, R9 write under sleep: all ignored
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1, 32'hDEAD_BEEF);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, 2, 32'hDEAD_BEEF);
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 3, 32'hDEAD_BEEF);
      sleep_i = 1'b1;
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 4, 32'hDEAD_BEEF);
      sleep_i = 1'b0;
      // R4 read with all byte selects set: no write
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '1, 6, 32'hDEAD_BEEF);
      check("R4 read valid", DW'(rvalid_o), 32'd1);
      check("R4 read data", rdata_o, model[6]);
      idle();

      // R5 flow-through read-back with R7 deselect between reads
      for (int a = 0; a < DEPTH; a++) begin
         rd(a);
         check("R5 flow valid", DW'(rvalid_o), 32'd1);
         check("R5 R2 R3 flow data", rdata_o, model[a]);
         idle();
         check("R7 flow deselect", DW'(rvalid_o), '0);
      end

      // R1 read with each enable wrong
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 7, '0);
      check("R1 ce_b low", DW'(rvalid_o), '0);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 7, '0);
      check("R1 ce_n high", DW'(rvalid_o), '0);

      // R8 output enable gates at once
      rd(9);
      #1 oe_i = 1'b0;
      #1 check("R8 oe valid", DW'(rvalid_o), '0);
      check("R8 oe data", rdata_o, '0);
      #1 oe_i = 1'b1;
      #1 check("R8 oe restore", rdata_o, model[9]);
      @(negedge clk);
      // R9 sleep gates at once
      rd(10);
      #1 sleep_i = 1'b1;
      #1 check("R9 sleep valid", DW'(rvalid_o), '0);
      #1 sleep_i = 1'b0;
      #1 check("R9 sleep retain", rdata_o, model[10]);
      @(negedge clk);

      // R11 write then read next edge
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 5, 32'h1234_ABCD);
      model[5] = 32'h1234_ABCD;
      rd(5);
      check("R11 write-read", rdata_o, 32'h1234_ABCD);
      idle();

      // R6 pipelined streaming read-back
      pipe_mode_i = 1'b1;
      idle();
      for (int a = 0; a <= DEPTH; a++) begin
         if (a < DEPTH) rd(a); else idle();
         if (a == 0) check("R6 pipe first slot empty", DW'(rvalid_o), '0);
         else check("R6 pipe data", rdata_o, model[a-1]);
      end
      idle();
      check("R7 pipe deselect", DW'(rvalid_o), '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule